// File: doc/BRIEF.md
# Serial Receive Character Buffer

This block sits between the deserialiser of an asynchronous serial receiver and the host. Each time the deserialiser finishes a character it pulses a done strobe with the data byte, an optional ninth data bit and a frame-error flag. The block keeps finished characters in a small circular FIFO. The host sees the oldest character and its status bits on the outputs, and it removes that character with a single read strobe. Because the pop discards the status together with the data, the host samples the status first and then pops.

When the FIFO is full, a newly finished character is not dropped. It is parked in a hold stage that stands for the receiver's shift register, which gives a third level of buffering. That character moves into the FIFO on the clock after a slot becomes free. The parked character is lost only when the receiver reports a new start bit, or a further completed character, while the FIFO is still full. In either case the next character that the block captures carries an overrun mark, and that mark travels through the FIFO with it.

Top module: `rx_char_buffer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the FIFO, discards any parked character and clears a pending overrun, so that `rx_avail` is 0 after the edge and no character from before the reset ever appears.
- R2: Characters leave in the order they arrived, and the FIFO holds up to DEPTH characters (default 2).
- R3: A `rd_pop` pulse while `rx_avail` is 1 removes the head entry at that clock edge. A `rd_pop` pulse while the buffer is empty has no effect.
- R4: `rx_data`, `rx_bit9`, `rx_ferr` and `rx_ovr` always show the head entry, each status bit belonging to that same character. `rx_avail` is 1 exactly when the FIFO is non-empty, and while it is 0 all four head outputs are 0.
- R5: A character completed while the FIFO is full is parked in the hold stage and kept there for as long as no start bit and no further character arrive.
- R6: A parked character enters the FIFO at the first clock edge at which the FIFO occupancy, as registered before that edge, is below DEPTH. That is one edge after the pop that freed the slot.
- R7: A `start_det` pulse while a character is parked and the FIFO is full discards the parked character, and the next character captured carries `rx_ovr` = 1.
- R8: A `char_done` pulse while a character is parked and the FIFO is full replaces the parked character, and the new character carries `rx_ovr` = 1.
- R9: A `start_det` pulse in any other situation changes nothing, and the characters that follow carry `rx_ovr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_done | input | 1 | One-cycle strobe: a character has finished |
| char_data | input | DATA_W | Data byte of the finished character |
| char_bit9 | input | 1 | Ninth data bit of the finished character |
| char_ferr | input | 1 | Frame error of the finished character |
| start_det | input | 1 | One-cycle strobe: the receiver detected a new start bit |
| rd_pop | input | 1 | Host read of the data port; pops the head entry |
| rx_avail | output | 1 | FIFO holds at least one character |
| rx_data | output | DATA_W | Head entry data |
| rx_bit9 | output | 1 | Head entry ninth bit |
| rx_ferr | output | 1 | Head entry frame error |
| rx_ovr | output | 1 | Head entry overrun mark |

## Verification
The assertions assume that `char_done` and `start_det` never pulse in the same cycle, since a start bit cannot be detected in the cycle that ends a character. One assertion states this rule about the inputs. The bench respects the rule in its directed sequences. Its random phase draws a single value per cycle that selects at most one of the two strobes, and it drives `rd_pop` independently of both.

// File: rtl/rx_char_buffer_pkg.sv
package rx_char_buffer_pkg;

   // Status bits that travel with every character.
   typedef struct packed {
      logic ovr;
      logic ferr;
      logic bit9;
   } rx_flags_t;

   // Destination of a freshly completed character.
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_RING = 2'd1,
      ROUTE_HOLD = 2'd2
   } route_e;

endpackage

// File: rtl/rxb_ring.sv
module rxb_ring
   import rx_char_buffer_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  rx_flags_t         wr_flags,
   input  logic              rd_en,
   output logic [DATA_W-1:0] head_data,
   output rx_flags_t         head_flags,
   output logic [CNT_W-1:0]  fill,
   output logic              full,
   output logic              empty
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] slot_data  [DEPTH];
   rx_flags_t         slot_flags [DEPTH];

   // Elaboration-time parameter checks.
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxb_ring: DEPTH must be a power of two, at least 2");
   end

   // Per-slot storage, written only when the write pointer selects it.
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            slot_data[s]  <= '0;
            slot_flags[s] <= '0;
         end else if (wr_en && wr_ptr == PTR_W'(s)) begin
            slot_data[s]  <= wr_data;
            slot_flags[s] <= wr_flags;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_data  = slot_data[rd_ptr];
   assign head_flags = slot_flags[rd_ptr];
   assign fill       = cnt_q;
   assign full       = (cnt_q == FULL_CNT);
   assign empty      = (cnt_q == '0);

   AST_RING_BOUND: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_en && full) |=> 1'b0) else $error("ring written while full"); // R2
   AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("pop did not shrink"); // R3

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
   import rx_char_buffer_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  rx_flags_t         load_flags,
   input  logic              clear,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output rx_flags_t         flags
);

   // A load wins over a clear: the old content drains the same cycle
   // the new character arrives.
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
         flags <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
         flags <= load_flags;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      load |=> valid) else $error("hold load lost"); // R5

endmodule

// File: rtl/rxb_route.sv
module rxb_route
   import rx_char_buffer_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      char_done,
   input  logic      start_det,
   input  logic      char_bit9,
   input  logic      char_ferr,
   input  logic      hold_valid,
   input  logic      fifo_full,
   output route_e    route,
   output logic      move_hold,
   output logic      drop_hold,
   output rx_flags_t cap_flags
);

   logic pend_q;
   logic lose_by_char;

   assign move_hold    = hold_valid && !fifo_full;
   assign drop_hold    = start_det && hold_valid && fifo_full;
   assign lose_by_char = char_done && hold_valid && fifo_full;

   always_comb begin
      if (!char_done)                    route = ROUTE_NONE;
      else if (!hold_valid && !fifo_full) route = ROUTE_RING;
      else                               route = ROUTE_HOLD;
   end

   always_comb begin
      cap_flags.ovr  = pend_q || lose_by_char;
      cap_flags.ferr = char_ferr;
      cap_flags.bit9 = char_bit9;
   end

   // Pending overrun waits for the next captured character.
   always_ff @(posedge clk) begin
      if (rst)            pend_q <= 1'b0;
      else if (drop_hold) pend_q <= 1'b1;
      else if (char_done) pend_q <= 1'b0;
   end

   AST_LOSS_MARKED: assert property (@(posedge clk) disable iff (rst)
      (start_det && hold_valid && fifo_full) |=> pend_q) else $error("loss not remembered"); // R7
   AST_MARK_CONSUMED: assert property (@(posedge clk) disable iff (rst)
      (char_done && !start_det) |=> !pend_q) else $error("overrun mark reused"); // R7
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(char_done && start_det)) else $error("done and start together"); // input rule

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
   import rx_char_buffer_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 2,
   parameter bit HAS_BIT9 = 1'b1,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_bit9,
   input  logic              char_ferr,
   input  logic              start_det,
   input  logic              rd_pop,
   output logic              rx_avail,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_ferr,
   output logic              rx_ovr
);

   if (DATA_W < 5 || DATA_W > 8) begin : g_bad_width
      $error("rx_char_buffer: DATA_W must lie in 5..8");
   end

   logic              bit9_in;
   route_e            route;
   logic              move_hold;
   logic              drop_hold;
   rx_flags_t         cap_flags;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   rx_flags_t         hold_flags;
   logic              ring_wr;
   logic [DATA_W-1:0] ring_wdata;
   rx_flags_t         ring_wflags;
   logic              rd_go;
   logic [DATA_W-1:0] head_data;
   rx_flags_t         head_flags;
   logic [CNT_W-1:0]  fill;
   logic              fifo_full;
   logic              fifo_empty;

   // Ninth bit is either carried or tied off.
   if (HAS_BIT9) begin : g_bit9
      assign bit9_in = char_bit9;
   end else begin : g_no_bit9
      assign bit9_in = 1'b0;
   end

   rxb_route u_route (
      .clk        (clk),
      .rst        (rst),
      .char_done  (char_done),
      .start_det  (start_det),
      .char_bit9  (bit9_in),
      .char_ferr  (char_ferr),
      .hold_valid (hold_valid),
      .fifo_full  (fifo_full),
      .route      (route),
      .move_hold  (move_hold),
      .drop_hold  (drop_hold),
      .cap_flags  (cap_flags)
   );

   rxb_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst        (rst),
      .load       (route == ROUTE_HOLD),
      .load_data  (char_data),
      .load_flags (cap_flags),
      .clear      (move_hold || drop_hold),
      .valid      (hold_valid),
      .data       (hold_data),
      .flags      (hold_flags)
   );

   // The parked character always has precedence over a direct capture.
   assign ring_wr     = move_hold || (route == ROUTE_RING);
   assign ring_wdata  = move_hold ? hold_data  : char_data;
   assign ring_wflags = move_hold ? hold_flags : cap_flags;
   assign rd_go       = rd_pop && !fifo_empty;

   rxb_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (ring_wr),
      .wr_data    (ring_wdata),
      .wr_flags   (ring_wflags),
      .rd_en      (rd_go),
      .head_data  (head_data),
      .head_flags (head_flags),
      .fill       (fill),
      .full       (fifo_full),
      .empty      (fifo_empty)
   );

   assign rx_avail = !fifo_empty;
   assign rx_data  = fifo_empty ? '0   : head_data;
   assign rx_bit9  = fifo_empty ? 1'b0 : head_flags.bit9;
   assign rx_ferr  = fifo_empty ? 1'b0 : head_flags.ferr;
   assign rx_ovr   = fifo_empty ? 1'b0 : head_flags.ovr;

   AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
      (hold_valid && fifo_full && !start_det && !char_done) |=> hold_valid) else $error("parked char lost"); // R5
   AST_HOLD_MOVES: assert property (@(posedge clk) disable iff (rst)
      (hold_valid && !fifo_full && !rd_go) |=> (fill == CNT_W'($past(fill) + 1'b1))) else $error("parked char stuck"); // R6
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
      (rd_pop && fifo_empty && !hold_valid && !char_done) |=> fifo_empty) else $error("empty pop acted"); // R3

endmodule

// File: tb/tb_rx_char_buffer.sv
module tb_rx_char_buffer;

   localparam int DW = 8;
   localparam int DEPTH = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          char_done = 1'b0;
   logic [DW-1:0] char_data = '0;
   logic          char_bit9 = 1'b0;
   logic          char_ferr = 1'b0;
   logic          start_det = 1'b0;
   logic          rd_pop = 1'b0;
   logic          rx_avail;
   logic [DW-1:0] rx_data;
   logic          rx_bit9, rx_ferr, rx_ovr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rx_char_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .HAS_BIT9(1'b1)) dut (
      .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
      .char_bit9(char_bit9), .char_ferr(char_ferr), .start_det(start_det),
      .rd_pop(rd_pop), .rx_avail(rx_avail), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
   );

   // Behavioural reference
   typedef struct { logic [DW-1:0] d; logic b9; logic fe; logic ov; } ent_t;
   ent_t q[$];
   ent_t m_hold;
   bit   m_hold_v;
   bit   m_pend;

   always @(posedge clk) begin
      if (rst) begin
         q.delete(); m_hold_v = 0; m_pend = 0;
      end else begin
         bit was_full, was_held;
         ent_t e;
         was_full = (q.size() == DEPTH);
         was_held = m_hold_v;
         if (rd_pop && q.size() > 0) void'(q.pop_front());
         if (was_held && !was_full) begin q.push_back(m_hold); m_hold_v = 0; end
         if (char_done) begin
            e.d = char_data; e.b9 = char_bit9; e.fe = char_ferr;
            e.ov = m_pend || (was_held && was_full);
            m_pend = 0;
            if (!was_held && !was_full) q.push_back(e);
            else begin m_hold = e; m_hold_v = 1; end
         end
         if (start_det && was_held && was_full) begin m_hold_v = 0; m_pend = 1; end
      end
   end

   task automatic check(string req, bit ok, string act, string exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the reference (R4 head view)
   always @(negedge clk) begin
      if (!rst && !done) begin
         logic [11:0] exp_v, act_v;
         act_v = {rx_avail, rx_data, rx_bit9, rx_ferr, rx_ovr};
         if (q.size() > 0) exp_v = {1'b1, q[0].d, q[0].b9, q[0].fe, q[0].ov};
         else              exp_v = '0;
         check("R4", act_v == exp_v, $sformatf("%h", act_v), $sformatf("%h", exp_v));
      end
   end

   // Directed helpers; each starts just after a falling edge.
   task automatic send(input logic [DW-1:0] d, input logic b9, input logic fe);
      char_done = 1; char_data = d; char_bit9 = b9; char_ferr = fe;
      @(negedge clk);
      char_done = 0;
   endtask

   task automatic pulse_start();
      start_det = 1; @(negedge clk); start_det = 0;
   endtask

   task automatic pop();
      rd_pop = 1; @(negedge clk); rd_pop = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_head(string req, bit av, logic [DW-1:0] d, bit b9, bit fe, bit ov);
      logic [11:0] a, e;
      a = {rx_avail, rx_data, rx_bit9, rx_ferr, rx_ovr};
      e = {av, d, b9, fe, ov};
      check(req, a == e, $sformatf("%h", a), $sformatf("%h", e));
   endtask

   task automatic do_reset();
      rst = 1; idle(2); rst = 0;
   endtask

   initial begin
      @(negedge clk);
      idle(2); rst = 0;
      // R1: reset state
      expect_head("R1", 0, 8'h00, 0, 0, 0);

      // R2 / R4: order and per-entry status
      send(8'hA1, 1, 0); send(8'hB2, 0, 1);
      expect_head("R4", 1, 8'hA1, 1, 0, 0);
      pop();
      expect_head("R2", 1, 8'hB2, 0, 1, 0);
      pop();
      expect_head("R2", 0, 8'h00, 0, 0, 0);

      // R3: pop on empty ignored
      pop(); idle(1);
      expect_head("R3", 0, 8'h00, 0, 0, 0);
      send(8'h33, 0, 0);
      expect_head("R3", 1, 8'h33, 0, 0, 0);
      pop();

      // R5 / R6: third character parked, then drains
      send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h5C, 1, 1);
      idle(5);
      expect_head("R5", 1, 8'h11, 0, 0, 0);
      pop();
      expect_head("R6", 1, 8'h22, 0, 0, 0);
      pop();
      expect_head("R6", 1, 8'h5C, 1, 1, 0);
      pop();
      expect_head("R5", 0, 8'h00, 0, 0, 0);

      // R7: start bit while parked and full
      send(8'h41, 0, 0); send(8'h42, 0, 0); send(8'h43, 0, 0);
      pulse_start();
      send(8'h44, 1, 0);
      pop(); idle(1); pop();
      expect_head("R7", 1, 8'h44, 1, 0, 1);
      pop();
      expect_head("R7", 0, 8'h00, 0, 0, 0);

      // R8: extra character while parked and full
      send(8'h61, 0, 0); send(8'h62, 0, 0); send(8'h63, 0, 0); send(8'h64, 0, 1);
      pop(); idle(1); pop();
      expect_head("R8", 1, 8'h64, 0, 1, 1);
      pop();

      // R9: harmless start bits
      send(8'h71, 0, 0); pulse_start(); send(8'h72, 0, 0); pulse_start();
      expect_head("R9", 1, 8'h71, 0, 0, 0);
      pop();
      expect_head("R9", 1, 8'h72, 0, 0, 0);
      pop();

      // R1: reset drops FIFO and parked character
      send(8'h81, 0, 0); send(8'h82, 0, 0); send(8'h83, 0, 0);
      do_reset();
      expect_head("R1", 0, 8'h00, 0, 0, 0);
      send(8'h91, 0, 0); pop(); idle(3);
      expect_head("R1", 0, 8'h00, 0, 0, 0);

      // Random traffic against the reference model
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 8;
         char_done = (r < 3);
         start_det = (r == 3);
         char_data = DW'($urandom);
         char_bit9 = $urandom % 2;
         char_ferr = ($urandom % 4) == 0;
         rd_pop    = ($urandom % 3) == 0;
         @(negedge clk);
      end
      char_done = 0; start_det = 0; rd_pop = 0;
      idle(2);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule